// File: doc/BRIEF.md
# Pseudorandom Upset Injection Scheduler

This block drives bench qualification of a configuration memory by emulating radiation upsets on demand. While enabled, it draws a pseudorandom target location (a page of the configuration image, a byte inside that page and a bit inside that byte) from a 32-bit maximal-length shift register. It then draws a pseudorandom delay and counts that delay down on a slow prescaled tick. When the count reaches zero it raises a single flip request towards a configuration-access engine. That engine performs the actual read-modify-write and acknowledges.

The block is meant for commissioning only, so it is idle after reset and does nothing until enabled. The mean spacing of injections is set by the tick prescaler (a parameter) together with a run-time delay width. These are chosen so that flips arrive roughly an order of magnitude more often than the upsets expected in operation. An injection counter reports how many flips the engine has accepted.

Top module: `fi_sched`

## Requirements
- R1: After reset the flip request is low, the injection count is zero and no injection is pending until the enable input is high.
- R2: The random source steps as a 32-bit Fibonacci register with feedback bit = s[31]^s[21]^s[1]^s[0], shifted in at bit 0 (polynomial x^32+x^22+x^2+x+1). While the block is idle and disabled it loads the seed input, and a seed of zero is replaced by 32'h5EED0001 (also its reset value).
- R3: Each injection takes four consecutive draws, one register step per draw, from the current state s. The page is (s*4504)>>32 and the byte is s[11:0]. The bit is s[2:0]. The delay is s with every bit at or above the delay-width input cleared.
- R4: The delay counts down by one on each prescaler tick, one tick every TICK_DIV cycles counted from the cycle after the delay draw. The request rises on the cycle after the count is seen at zero.
- R5: Once raised, the request stays high and its page, byte and bit fields stay unchanged until the cycle in which the acknowledge is sampled high.
- R6: An acknowledge sampled with the request high adds one to the injection count and drops the request. No new draw or countdown starts before that acknowledge.
- R7: An acknowledge sampled while no request is raised leaves the injection count and the request unchanged.
- R8: Dropping enable before the request is raised abandons the pending injection, with no request and no count change. Dropping it while the request is high does not withdraw the request.
- R9: Every requested page index is below 4504.
- R10: With a delay width of zero the request rises on the sixth clock edge after enable is first sampled high from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the injection schedule |
| seed_i | input | 32 | Seed loaded while idle and disabled |
| dly_bits_i | input | 5 | Number of low delay bits kept from a draw (0..24) |
| flip_req_o | output | 1 | Flip request to the access engine |
| flip_page_o | output | 13 | Target page index |
| flip_byte_o | output | 12 | Target byte within the page |
| flip_bit_o | output | 3 | Target bit within the byte |
| flip_ack_i | input | 1 | Engine acknowledge of the flip |
| inj_count_o | output | 16 | Number of acknowledged flips, wrapping |

## Verification
The hardest case to reach from the ports is a disable that lands inside a running countdown or on a raised request. It has to fall at a known point of a pseudorandom schedule. The bench keeps a behavioural model in lock-step, so it always knows the current phase. It drops enable only once the model reports a countdown with a nonzero remainder, or a request the responder is holding back with a long acknowledge latency. Stray acknowledges are pulsed while the block is idle, and a zero delay width is used to pin down the exact request latency.

// File: rtl/fi_pkg.sv
package fi_pkg;
    localparam int unsigned RND_W = 32;
    localparam logic [RND_W-1:0] SEED_FALLBACK = 32'h5EED_0001;
    localparam int unsigned BIT_IDX_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_BYTE,
        ST_BIT,
        ST_DLY,
        ST_WAIT,
        ST_REQ
    } fi_state_e;
endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr
    import fi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RND_W-1:0] seed_i,
    input  logic             step_i,
    output logic [RND_W-1:0] state_o
);
    logic [RND_W-1:0] state_d, state_q;
    logic             fb;

    always_comb begin
        fb      = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
        state_d = state_q;
        if (load_i) begin
            state_d = (seed_i == '0) ? SEED_FALLBACK : seed_i;
        end else if (step_i) begin
            state_d = {state_q[RND_W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED_FALLBACK;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/fi_tick.sv
module fi_tick #(
    parameter int unsigned TICK_DIV = 1000,
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && at_last;
endmodule

// File: rtl/fi_scale.sv
module fi_scale
    import fi_pkg::*;
#(
    parameter int unsigned RANGE = 4504,
    localparam int unsigned OW = (RANGE > 1) ? $clog2(RANGE) : 1
) (
    input  logic [RND_W-1:0] rnd_i,
    output logic [OW-1:0]    idx_o
);
    localparam logic [OW-1:0] RANGE_V = OW'(RANGE);

    logic [RND_W+OW-1:0] prod;

    always_comb begin
        prod  = (RND_W+OW)'(rnd_i) * (RND_W+OW)'(RANGE_V);
        idx_o = prod[RND_W+OW-1:RND_W];
    end
endmodule

// File: rtl/fi_sched.sv
module fi_sched
    import fi_pkg::*;
#(
    parameter int unsigned PAGES      = 4504,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned TICK_DIV   = 1000000,
    parameter int unsigned DLY_MAX    = 24,
    parameter int unsigned CNT_W      = 16,
    localparam int unsigned PW  = $clog2(PAGES),
    localparam int unsigned BW  = $clog2(PAGE_BYTES),
    localparam int unsigned DBW = $clog2(DLY_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [RND_W-1:0]     seed_i,
    input  logic [DBW-1:0]       dly_bits_i,
    output logic                 flip_req_o,
    output logic [PW-1:0]        flip_page_o,
    output logic [BW-1:0]        flip_byte_o,
    output logic [BIT_IDX_W-1:0] flip_bit_o,
    input  logic                 flip_ack_i,
    output logic [CNT_W-1:0]     inj_count_o
);
    typedef struct packed {
        fi_state_e              st;
        logic [PW-1:0]          page;
        logic [BW-1:0]          byte_idx;
        logic [BIT_IDX_W-1:0]   bit_idx;
        logic [DLY_MAX-1:0]     dly;
        logic [CNT_W-1:0]       count;
    } sched_t;

    sched_t r_d, r_q;

    logic [RND_W-1:0]   rnd;
    logic [PW-1:0]      page_scaled;
    logic [DLY_MAX-1:0] dly_mask;
    logic               rnd_load, rnd_step;
    logic               tick, tick_clr, tick_run;

    fi_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rnd_load),
        .seed_i  (seed_i),
        .step_i  (rnd_step),
        .state_o (rnd)
    );

    fi_scale #(.RANGE(PAGES)) u_scale (
        .rnd_i (rnd),
        .idx_o (page_scaled)
    );

    fi_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .run_i  (tick_run),
        .tick_o (tick)
    );

    generate
        for (genvar i = 0; i < DLY_MAX; i++) begin : g_mask
            assign dly_mask[i] = (DBW'(i) < dly_bits_i);
        end
    endgenerate

    assign tick_clr = (r_q.st == ST_DLY);
    assign tick_run = (r_q.st == ST_WAIT);

    always_comb begin
        r_d      = r_q;
        rnd_load = 1'b0;
        rnd_step = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!en_i) rnd_load = 1'b1;
                else       r_d.st   = ST_PAGE;
            end
            ST_PAGE: begin
                if (!en_i) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.page = page_scaled;
                    rnd_step = 1'b1;
                    r_d.st   = ST_BYTE;
                end
            end
            ST_BYTE: begin
                if (!en_i) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.byte_idx = rnd[BW-1:0];
                    rnd_step     = 1'b1;
                    r_d.st       = ST_BIT;
                end
            end
            ST_BIT: begin
                if (!en_i) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.bit_idx = rnd[BIT_IDX_W-1:0];
                    rnd_step    = 1'b1;
                    r_d.st      = ST_DLY;
                end
            end
            ST_DLY: begin
                if (!en_i) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.dly  = rnd[DLY_MAX-1:0] & dly_mask;
                    rnd_step = 1'b1;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!en_i) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.dly == '0) begin
                    r_d.st = ST_REQ;
                end else if (tick) begin
                    r_d.dly = r_q.dly - 1'b1;
                end
            end
            ST_REQ: begin
                if (flip_ack_i) begin
                    r_d.count = r_q.count + 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign flip_req_o  = (r_q.st == ST_REQ);
    assign flip_page_o = r_q.page;
    assign flip_byte_o = r_q.byte_idx;
    assign flip_bit_o  = r_q.bit_idx;
    assign inj_count_o = r_q.count;
endmodule

// File: rtl/fi_sched_chk.sv
module fi_sched_chk #(
    parameter int unsigned PAGES = 4504,
    parameter int unsigned PW    = 13,
    parameter int unsigned BW    = 12,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             flip_req_o,
    input logic [PW-1:0]    flip_page_o,
    input logic [BW-1:0]    flip_byte_o,
    input logic [2:0]       flip_bit_o,
    input logic             flip_ack_i,
    input logic [CNT_W-1:0] inj_count_o
);
    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_req_o && !flip_ack_i) |=> flip_req_o);

    p_fields_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_req_o && !flip_ack_i) |=>
            ($stable(flip_page_o) && $stable(flip_byte_o) && $stable(flip_bit_o)));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_req_o && flip_ack_i) |=>
            (inj_count_o == CNT_W'($past(inj_count_o) + 1'b1)) && !flip_req_o);

    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flip_req_o && flip_ack_i) |=> $stable(inj_count_o));

    p_no_req_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !flip_req_o) |=> !flip_req_o);

    p_page_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flip_req_o |-> (32'(flip_page_o) < PAGES));
endmodule

bind fi_sched fi_sched_chk #(
    .PAGES (PAGES),
    .PW    (PW),
    .BW    (BW),
    .CNT_W (CNT_W)
) u_fi_sched_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .flip_req_o  (flip_req_o),
    .flip_page_o (flip_page_o),
    .flip_byte_o (flip_byte_o),
    .flip_bit_o  (flip_bit_o),
    .flip_ack_i  (flip_ack_i),
    .inj_count_o (inj_count_o)
);

// File: tb/tb_fi_sched.sv
module tb_fi_sched;
    localparam int TDIV  = 3;
    localparam int DMAX  = 8;
    localparam int NPAGE = 4504;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] seed = 32'h0;
    logic [3:0]  dly_bits = 4'd3;
    logic        req;
    logic [12:0] page;
    logic [11:0] byte_o;
    logic [2:0]  bit_o;
    logic        ack;
    logic        resp_ack = 1'b0;
    logic        stray_ack = 1'b0;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_lat = 1;
    int lat_cnt = 0;
    bit resp_on = 1'b1;

    // reference model state
    int          m_st = 0;   // 0 idle,1 page,2 byte,3 bit,4 delay draw,5 countdown,6 request
    logic [31:0] m_r = 32'h5EED_0001;
    int          m_page = 0, m_byte = 0, m_bit = 0, m_dly = 0, m_pre = 0;
    int          m_count = 0;

    assign ack = resp_ack | stray_ack;

    always #2 clk = ~clk;

    fi_sched #(.TICK_DIV(TDIV), .DLY_MAX(DMAX)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .seed_i      (seed),
        .dly_bits_i  (dly_bits),
        .flip_req_o  (req),
        .flip_page_o (page),
        .flip_byte_o (byte_o),
        .flip_bit_o  (bit_o),
        .flip_ack_i  (ack),
        .inj_count_o (count)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_r = 32'h5EED_0001; m_page = 0; m_byte = 0;
            m_bit = 0; m_dly = 0; m_pre = 0; m_count = 0;
        end else begin
            bit tk;
            tk = (m_pre == TDIV - 1);
            if (m_st == 4) m_pre = 0;
            else if (m_st == 5) m_pre = tk ? 0 : m_pre + 1;
            case (m_st)
                0: if (!en) m_r = (seed == 0) ? 32'h5EED_0001 : seed; else m_st = 1;
                1: if (!en) m_st = 0;
                   else begin
                       m_page = int'((longint'(m_r) * NPAGE) >>> 32);
                       m_r = nxt(m_r); m_st = 2;
                   end
                2: if (!en) m_st = 0;
                   else begin m_byte = m_r % 4096; m_r = nxt(m_r); m_st = 3; end
                3: if (!en) m_st = 0;
                   else begin m_bit = m_r % 8; m_r = nxt(m_r); m_st = 4; end
                4: if (!en) m_st = 0;
                   else begin m_dly = m_r % (1 << dly_bits); m_r = nxt(m_r); m_st = 5; end
                5: if (!en) m_st = 0;
                   else if (m_dly == 0) m_st = 6;
                   else if (tk) m_dly = m_dly - 1;
                6: if (ack) begin m_count = (m_count + 1) % 65536; m_st = 0; end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // lock-step comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        chk(req == (m_st == 6), "R4/R6/R8 request", int'(req), int'(m_st == 6));
        chk(int'(count) == m_count, "R1/R6/R7 count", int'(count), m_count);
        if (m_st == 6) begin
            chk(int'(page) == m_page, "R2/R3 page", int'(page), m_page);
            chk(int'(byte_o) == m_byte, "R3 byte", int'(byte_o), m_byte);
            chk(int'(bit_o) == m_bit, "R3 bit", int'(bit_o), m_bit);
            chk(int'(page) < NPAGE, "R9 page range", int'(page), NPAGE - 1);
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // access-engine responder
    always @(negedge clk) begin
        if (resp_ack) begin
            resp_ack <= 1'b0;
            lat_cnt  <= 0;
        end else if (req && resp_on) begin
            if (lat_cnt >= ack_lat) resp_ack <= 1'b1;
            else                    lat_cnt  <= lat_cnt + 1;
        end
    end

    task automatic wait_count(input int n);
        while (int'(count) < n) @(negedge clk);
    endtask

    initial begin
        int c0;
        int t;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req == 1'b0, "R1 reset request", int'(req), 0);
        chk(count == 16'd0, "R1 reset count", int'(count), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(req == 1'b0, "R1 idle without enable", int'(req), 0);

        // R7: stray acknowledges while idle
        for (int i = 0; i < 3; i++) begin
            stray_ack = 1'b1; @(negedge clk); stray_ack = 1'b0; @(negedge clk);
        end
        chk(count == 16'd0, "R7 stray ack ignored", int'(count), 0);

        // R2: zero seed replaced, several injections
        seed = 32'h0; dly_bits = 4'd3; ack_lat = 2;
        @(negedge clk); en = 1'b1;
        wait_count(6);
        // R2/R3: non-zero seed, wider delay, fast acknowledge
        en = 1'b0; seed = 32'hDEAD_BEEF; dly_bits = 4'd5; ack_lat = 0;
        repeat (3) @(negedge clk); en = 1'b1;
        wait_count(14);
        chk(int'(count) == 14, "R6 injections counted", int'(count), 14);

        // R5: slow engine holds the request
        ack_lat = 25; dly_bits = 4'd2;
        wait_count(17);

        // R8: disable inside a countdown with remaining delay
        dly_bits = 4'd6;
        while (!(m_st == 5 && m_dly > 2)) @(negedge clk);
        en = 1'b0; c0 = int'(count);
        repeat (60) @(negedge clk);
        chk(req == 1'b0, "R8 countdown aborted", int'(req), 0);
        chk(int'(count) == c0, "R8 no injection while disabled", int'(count), c0);

        // R8: disable while request raised keeps the request
        resp_on = 1'b0; dly_bits = 4'd1; seed = 32'h1234_5678;
        @(negedge clk); en = 1'b1;
        while (!req) @(negedge clk);
        en = 1'b0;
        repeat (10) @(negedge clk);
        chk(req == 1'b1, "R8 request not withdrawn", int'(req), 1);
        resp_on = 1'b1; ack_lat = 0;
        repeat (4) @(negedge clk);
        chk(int'(count) == c0 + 1, "R6 late ack counted", int'(count), c0 + 1);

        // R10: zero delay width gives fixed latency
        dly_bits = 4'd0; repeat (2) @(negedge clk);
        en = 1'b1; t = 0;
        while (!req && t < 20) begin @(negedge clk); t++; end
        chk(t == 6, "R10 zero-delay latency", t, 6);
        en = 1'b0;
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule